// File: doc/BRIEF.md
# Packed Signed Lane Adder with Sign Flags

This block adds or subtracts two 32-bit words treated as packed signed lanes: either two 16-bit lanes or four 8-bit lanes. Every lane is computed independently; the carry out of one lane never reaches its neighbour. The value written to each lane is the lane-width truncation of the exact result, so it wraps around on overflow.

Beside the packed result, the block returns a 4-bit vector of greater-or-equal flags. Each flag comes from the sign of the exact result, which is one bit wider than the lane. It does not come from the wrapped lane value. A later select or compare stage can therefore rely on these flags even when the lane overflowed.

The block is a single registered stage. An operation offered with `in_valid` appears on the outputs one clock later, together with `out_valid`. The outputs keep their last values until the next operation arrives.

Top module: `simd_ge_adder`

## Requirements
- R1: While `rst_n` is low, and until the first operation completes after reset, `out_valid` is 0, `result` is 0 and `ge` is 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle in which `in_valid` was 1, and 0 otherwise.
- R3: In byte mode (`lane_mode` = 1) with `op_sub` = 0, result bits [8n+7:8n] equal the low 8 bits of the sign-extended sum of operand bytes n, for n = 0..3.
- R4: In byte mode with `op_sub` = 1, result bits [8n+7:8n] equal the low 8 bits of the sign-extended byte n of `op_a` minus byte n of `op_b`.
- R5: In halfword mode (`lane_mode` = 0), result bits [16n+15:16n] equal the low 16 bits of the sign-extended sum (`op_sub` = 0) or difference (`op_sub` = 1) of operand halfwords n, for n = 0..1.
- R6: In byte mode, `ge[n]` is 1 exactly when the exact signed result of byte lane n is zero or positive.
- R7: In halfword mode, `ge[2n]` and `ge[2n+1]` are both 1 when the exact signed result of halfword lane n is zero or positive, and both 0 otherwise.
- R8: The flags follow the exact result even when the lane wraps. For example, 0x7F + 0x01 gives lane value 0x80 with its flag set, and 0x80 - 0x01 gives lane value 0x7F with its flag clear.
- R9: In a cycle after `in_valid` was 0, `result` and `ge` keep their previous values. Every flag bit is recomputed by each new operation; no flag is carried over from an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered this cycle |
| op_a | input | 32 | First packed operand |
| op_b | input | 32 | Second packed operand (subtrahend) |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| lane_mode | input | 1 | 0 = two 16-bit lanes, 1 = four 8-bit lanes |
| out_valid | output | 1 | Result and flags belong to an operation from the previous cycle |
| result | output | 32 | Packed wrapped lane results |
| ge | output | 4 | Greater-or-equal flags per lane |

## Verification
The assertions assume that `in_valid`, `op_sub` and `lane_mode` are always driven to 0 or 1, never X, and that reset lasts at least one clock edge. The bench drives every input on the falling clock edge, always to a known value, and holds `rst_n` low for several edges before the first operation. The operands mix random words with the lane extremes 0x80, 0x7F, 0x8000 and 0x7FFF. Pairs of these extremes are chosen so that the wrapped lane value and the exact result have opposite signs.

// File: rtl/simd_ge_adder_pkg.sv
package simd_ge_adder_pkg;
    localparam int DATA_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = 16;
    localparam int N_BYTE  = DATA_W / BYTE_W;
    localparam int N_HALF  = DATA_W / HALF_W;
    localparam int GE_W    = N_BYTE;

    typedef enum logic {
        LM_HALF = 1'b0,
        LM_BYTE = 1'b1
    } lane_mode_e;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic [GE_W-1:0]   ge;
    } stage_t;
endpackage

// File: rtl/simd_lane_slice.sv
module simd_lane_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] wrapped,
    output logic         nonneg
);
    logic signed [W:0] a_ext;
    logic signed [W:0] b_ext;
    logic signed [W:0] full;

    always_comb begin
        a_ext   = $signed({a[W-1], a});
        b_ext   = $signed({b[W-1], b});
        full    = sub ? (a_ext - b_ext) : (a_ext + b_ext);
        wrapped = full[W-1:0];
        nonneg  = ~full[W];
    end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0]        a,
    input  logic [DATA_W-1:0]        b,
    input  logic                     sub,
    output logic [DATA_W-1:0]        packed_res,
    output logic [DATA_W/LANE_W-1:0] lane_nonneg
);
    localparam int LANES = DATA_W / LANE_W;

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        simd_lane_slice #(.W(LANE_W)) i_slice (
            .a       (a[n*LANE_W +: LANE_W]),
            .b       (b[n*LANE_W +: LANE_W]),
            .sub     (sub),
            .wrapped (packed_res[n*LANE_W +: LANE_W]),
            .nonneg  (lane_nonneg[n])
        );
    end
endmodule

// File: rtl/simd_ge_adder.sv
module simd_ge_adder
    import simd_ge_adder_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              op_sub,
    input  logic              lane_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [GE_W-1:0]   ge
);
    localparam int SPREAD = HALF_W / BYTE_W;

    logic [DATA_W-1:0] byte_res;
    logic [N_BYTE-1:0] byte_nn;
    logic [DATA_W-1:0] half_res;
    logic [N_HALF-1:0] half_nn;
    logic [GE_W-1:0]   half_ge;

    stage_t st_d, st_q;

    simd_lane_bank #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) i_byte_bank (
        .a           (op_a),
        .b           (op_b),
        .sub         (op_sub),
        .packed_res  (byte_res),
        .lane_nonneg (byte_nn)
    );

    simd_lane_bank #(.DATA_W(DATA_W), .LANE_W(HALF_W)) i_half_bank (
        .a           (op_a),
        .b           (op_b),
        .sub         (op_sub),
        .packed_res  (half_res),
        .lane_nonneg (half_nn)
    );

    for (genvar h = 0; h < N_HALF; h++) begin : g_spread
        assign half_ge[h*SPREAD +: SPREAD] = {SPREAD{half_nn[h]}};
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (lane_mode_e'(lane_mode) == LM_BYTE) begin
                st_d.res = byte_res;
                st_d.ge  = byte_nn;
            end else begin
                st_d.res = half_res;
                st_d.ge  = half_ge;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign ge        = st_q.ge;
endmodule

// File: rtl/simd_ge_adder_chk.sv
module simd_ge_adder_chk
    import simd_ge_adder_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              op_sub,
    input logic              lane_mode,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [GE_W-1:0]   ge
);
    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0 && ge == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == $past(in_valid)));

    a_r4_self_sub_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sub && op_a == op_b) |=> (result == '0 && ge == '1));

    a_r7_half_ge_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode == 1'b0) |=> (ge[0] == ge[1] && ge[2] == ge[3]));

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !in_valid) |=> ($stable(result) && $stable(ge)));
endmodule

bind simd_ge_adder simd_ge_adder_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sub    (op_sub),
    .lane_mode (lane_mode),
    .out_valid (out_valid),
    .result    (result),
    .ge        (ge)
);

// File: tb/test_simd_ge_adder.sv
module test_simd_ge_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        op_sub = 1'b0;
    logic        lane_mode = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  ge;

    typedef struct packed {
        logic [31:0] res;
        logic [3:0]  ge;
        logic        sub;
        logic        mode;
        logic        edge_case;
    } exp_t;

    exp_t exp_q[$];
    exp_t last_exp;
    logic have_last = 1'b0;
    int   n_checks = 0;
    int   n_fail = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    simd_ge_adder i_simd_ge_adder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .op_sub(op_sub), .lane_mode(lane_mode), .out_valid(out_valid),
        .result(result), .ge(ge)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input logic sub, input logic mode);
        exp_t e;
        e = '0;
        e.sub = sub;
        e.mode = mode;
        if (mode) begin
            for (int n = 0; n < 4; n++) begin
                int x, y, s;
                x = int'($signed(a[8*n +: 8]));
                y = int'($signed(b[8*n +: 8]));
                s = sub ? x - y : x + y;
                e.res[8*n +: 8] = s[7:0];
                e.ge[n] = (s >= 0);
            end
        end else begin
            for (int n = 0; n < 2; n++) begin
                int x, y, s;
                x = int'($signed(a[16*n +: 16]));
                y = int'($signed(b[16*n +: 16]));
                s = sub ? x - y : x + y;
                e.res[16*n +: 16] = s[15:0];
                e.ge[2*n] = (s >= 0);
                e.ge[2*n+1] = (s >= 0);
            end
        end
        return e;
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic sub, input logic mode, input logic edge_case);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; op_sub = sub; lane_mode = mode;
        e = model(a, b, sub, mode);
        e.edge_case = edge_case;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a = $urandom; op_b = $urandom; op_sub = $urandom; lane_mode = $urandom;
        end
    endtask

    // Monitor: sampled on the falling edge, after the registered update.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (out_valid) begin
                    exp_t e;
                    if (exp_q.size() == 0) begin
                        check("R2 unexpected out_valid", 32'(out_valid), 32'd0);
                    end else begin
                        string rr, rg;
                        e = exp_q.pop_front();
                        if (e.mode) rr = e.sub ? "R4 byte sub" : "R3 byte add";
                        else        rr = "R5 half add/sub";
                        rg = e.mode ? "R6 byte ge" : "R7 half ge";
                        if (e.edge_case) begin
                            rr = {"R8 wrap ", rr};
                            rg = {"R8 wrap ", rg};
                        end
                        check(rr, result, e.res);
                        check(rg, 32'(ge), 32'(e.ge));
                        last_exp = e;
                        have_last = 1'b1;
                    end
                end else if (have_last) begin
                    check("R9 hold result", result, last_exp.res);
                    check("R9 hold ge", 32'(ge), 32'(last_exp.ge));
                end
                if (exp_q.size() > 1)
                    check("R2 missing out_valid", 32'(out_valid), 32'd1);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset valid", 32'(out_valid), 32'd0);
        check("R1 reset result", result, 32'd0);
        check("R1 reset ge", 32'(ge), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset valid", 32'(out_valid), 32'd0);
        check("R1 post-reset ge", 32'(ge), 32'd0);

        // R8: wrapped value and exact sign disagree
        drive(32'h7F7F_7F7F, 32'h0101_0101, 1'b0, 1'b1, 1'b1);
        drive(32'h8080_8080, 32'h0101_0101, 1'b1, 1'b1, 1'b1);
        drive(32'h7FFF_7FFF, 32'h0001_7FFF, 1'b0, 1'b0, 1'b1);
        drive(32'h8000_8000, 32'h0001_7FFF, 1'b1, 1'b0, 1'b1);
        drive(32'h7F80_807F, 32'h807F_7F80, 1'b1, 1'b1, 1'b1);
        drive(32'h8000_7FFF, 32'h8000_8000, 1'b0, 1'b0, 1'b1);
        idle(3);
        // R9: a negative-lane op after an all-set op clears flags
        drive(32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1, 1'b0);
        drive(32'h0000_0000, 32'h0101_0101, 1'b1, 1'b1, 1'b0);
        drive(32'h1234_5678, 32'h1234_5678, 1'b1, 1'b0, 1'b0);
        idle(2);
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            a = $urandom; b = $urandom;
            if (i % 7 == 0) a[7:0] = 8'h80;
            if (i % 5 == 0) b[31:16] = 16'h7FFF;
            drive(a, b, 1'($urandom), 1'($urandom), 1'b0);
            if (i % 11 == 0) idle(1 + (i % 3));
        end
        idle(3);
        check("R2 queue drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule